// File: doc/BRIEF.md
# Word-packed I2C master controller

This block is a single-master I2C controller that carries host data as whole 24-bit words. Each word is split into one, two or three bytes on the bus. The host starts a session by writing an address word while the controller reports idle. The controller then issues a start condition and sends one address byte. If the target acknowledges, the controller enters a receive or a transmit session, chosen by the direction bit of that byte.

Inside a session the controller moves data between the bus and two host-side structures. Outgoing words come from a single transmit holding register. Incoming words go into a small receive FIFO. The controller stops SCL at word boundaries when it cannot go on: in a receive session when the FIFO has no room, in a transmit session when no data is waiting, and in either session while an optional ready handshake from the target is low. To end a session the host raises a terminate request. In a transmit session a missing acknowledge ends the session with a bus error. The SCL rate comes from a programmable divider, and each SCL period is four divider ticks long.

Top module: `i2c_word_master`

## Requirements
- R1: After reset the block reports idle, releases SCL and SDA, shows an empty receive FIFO, shows the transmit holding register empty, and has the bus-error and interrupt outputs low.
- R2: The idle output is high exactly when no session is active. A write to the transmit port while idle starts a session. The start condition is followed by one address byte taken from tx_data[23:16], most significant bit first, with bit 16 as the R/W bit. tx_data[15:0] of that write is ignored. A terminate request made while idle has no effect.
- R3: If the address byte is not acknowledged, the block sets the bus-error flag, asserts irq when irq_en is high, and produces a stop condition. The bus-error flag stays set until the next session starts, and starting a session clears it.
- R4: word_len selects the bytes per host word: 00 gives one byte, 01 gives two, 10 gives three, and 11 is treated as one byte. Words are left-justified. The first byte on the bus is bits 23:16 of the word, and unused low bytes of a received word read as zero.
- R5: In a transmit session (R/W=0) the holding register is copied into the shift register at each word boundary, and tx_empty rises at that moment. Bits go out MSB first. A missing acknowledge on any data byte sets bus-error, produces a stop condition and ends the session. No further byte is sent after it.
- R6: In a transmit session with no word waiting at a word boundary, SCL is held low and the session stays active. A host write resumes transfer. A terminate request instead produces a stop condition with no further data.
- R7: In a receive session (R/W=1) bits are taken MSB first, and the controller drives ACK after each byte. A word is pushed into the FIFO only after all of its bytes have arrived. rx_ne rises only through such a push.
- R8: A terminate request made during the address byte or during a data word makes the controller NACK the last byte of the next data word. That word is still pushed into the FIFO, and a stop condition follows.
- R9: The receive FIFO holds 4 words. When it is full and the last byte of a word has arrived, SCL is held low before the acknowledge bit. Reading a word releases the stall and reception continues with no word lost.
- R10: With req_en high, each word boundary waits with SCL low until req_in is high. With req_en low, req_in has no effect.
- R11: The SCL period is 4*(clk_div+1) system clocks. During data bits, sda_low changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | SCL divider; one phase lasts clk_div+1 clocks |
| word_len | input | 2 | Bytes per host word (00=1, 01=2, 10=3, 11=1) |
| req_en | input | 1 | Enables the ready handshake at word boundaries |
| irq_en | input | 1 | Enables irq from the bus-error flag |
| tx_wr | input | 1 | Write strobe for the transmit port |
| tx_data | input | 24 | Address word when idle, otherwise data for the holding register |
| idle_req | input | 1 | Terminate request pulse |
| rx_rd | input | 1 | Pops one word from the receive FIFO |
| rx_data | output | 24 | Word at the head of the receive FIFO |
| rx_ne | output | 1 | Receive FIFO not empty |
| tx_empty | output | 1 | Transmit holding register empty |
| bus_err | output | 1 | Missing acknowledge seen in this session |
| irq | output | 1 | Bus-error interrupt |
| idle | output | 1 | No session active |
| scl_low | output | 1 | Pull SCL low (open drain) |
| sda_low | output | 1 | Pull SDA low (open drain) |
| sda_in | input | 1 | Level on the SDA wire |
| req_in | input | 1 | Target-ready handshake |

## Verification
On every cycle the assertions check a fixed set of rules. SDA is steady whenever SCL stays high during data bits. The FIFO count never exceeds its depth. A full FIFO at the acknowledge slot keeps SCL low. A missing acknowledge in the address or transmit path leads straight to a stop with bus-error set. rx_ne never rises without a push. Some behaviours need a bus partner and a time scale, so only the bench scenarios can show them. These are byte ordering for each word length, NACK placement after a terminate request, the transmit stall and how it resumes, word preservation across a FIFO stall, the handshake gate, and the measured SCL period.

// File: rtl/i2c_word_master.sv
module i2c_word_master #(
  parameter int DIV_W = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [1:0]       word_len,
  input  logic             req_en,
  input  logic             irq_en,
  input  logic             tx_wr,
  input  logic [23:0]      tx_data,
  input  logic             idle_req,
  input  logic             rx_rd,
  output logic [23:0]      rx_data,
  output logic             rx_ne,
  output logic             tx_empty,
  output logic             bus_err,
  output logic             irq,
  output logic             idle,
  output logic             scl_low,
  output logic             sda_low,
  input  logic             sda_in,
  input  logic             req_in
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_XFER, S_STOP} st_t;
  typedef enum logic [1:0] {M_ADDR, M_TX, M_RX} md_t;

  st_t             st;
  md_t             md;
  logic [1:0]      ph;
  logic [3:0]      bitn;
  logic [1:0]      bidx;
  logic [23:0]     sw;
  logic [23:0]     txh;
  logic            txv, rw, ackin, term, armed;
  logic [DIV_W-1:0] div_cnt;
  logic [23:0]     mem [FIFO_DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic [23:0]     rx_word;
  logic [1:0]      nb_m1;

  assign nb_m1 = (word_len == 2'd1) ? 2'd1 : (word_len == 2'd2) ? 2'd2 : 2'd0;

  wire tick     = (div_cnt == clk_div);
  wire last_b   = (bidx == nb_m1);
  wire word_end = (md == M_ADDR) || last_b;
  wire req_hold = req_en && !req_in;
  wire full     = (cnt == CW'(FIFO_DEPTH));
  wire rx_nack  = (md == M_RX) && armed && last_b;
  wire ack_slot = (st == S_XFER) && (bitn == 4'd8);
  wire push     = ack_slot && (md == M_RX) && (ph == 2'd0) && tick && last_b && !full;
  wire pop      = rx_rd && rx_ne;

  always_comb begin
    case (word_len)
      2'd1:    rx_word = {sw[15:0], 8'h00};
      2'd2:    rx_word = sw;
      default: rx_word = {sw[7:0], 16'h0000};
    endcase
  end

  assign idle     = (st == S_IDLE);
  assign tx_empty = !txv;
  assign irq      = bus_err && irq_en;
  assign rx_ne    = (cnt != '0);
  assign rx_data  = mem[rp];

  assign scl_low = ((st == S_START) && (ph == 2'd3)) ||
                   ((st == S_XFER) && ((ph == 2'd0) || (ph == 2'd3))) ||
                   ((st == S_STOP) && (ph == 2'd0));

  always_comb begin
    case (st)
      S_START: sda_low = (ph != 2'd0);
      S_STOP:  sda_low = (ph < 2'd2);
      S_XFER:  sda_low = (bitn == 4'd8) ? ((md == M_RX) && !rx_nack)
                                        : ((md != M_RX) && !sw[23]);
      default: sda_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; md <= M_ADDR; ph <= '0; bitn <= '0; bidx <= '0;
      sw <= '0; txh <= '0; txv <= 1'b0; rw <= 1'b0; ackin <= 1'b0;
      term <= 1'b0; armed <= 1'b0; div_cnt <= '0; bus_err <= 1'b0;
    end else begin
      div_cnt <= (st == S_IDLE || tick) ? '0 : div_cnt + 1'b1;

      if (tick) begin
        case (st)
          S_START: begin
            if (ph == 2'd3) begin
              st <= S_XFER; ph <= '0; bitn <= '0;
            end else ph <= ph + 2'd1;
          end
          S_STOP: begin
            if (ph == 2'd3) begin
              st <= S_IDLE; term <= 1'b0; armed <= 1'b0;
            end else ph <= ph + 2'd1;
          end
          S_XFER: begin
            case (ph)
              2'd0: if (!(bitn == 4'd8 && md == M_RX && last_b && full)) ph <= 2'd1;
              2'd1: begin
                ph <= 2'd2;
                if (bitn == 4'd8) ackin <= sda_in;
                else if (md == M_RX) sw <= {sw[22:0], sda_in};
              end
              2'd2: ph <= 2'd3;
              default: begin
                if (bitn != 4'd8) begin
                  bitn <= bitn + 4'd1; ph <= '0;
                  if (md != M_RX) sw <= {sw[22:0], 1'b0};
                end else if (md != M_RX && ackin) begin
                  bus_err <= 1'b1; st <= S_STOP; ph <= '0;
                end else if (rx_nack) begin
                  st <= S_STOP; ph <= '0;
                end else if (!word_end) begin
                  bidx <= bidx + 2'd1; bitn <= '0; ph <= '0;
                end else if (md == M_RX || rw) begin
                  if (!req_hold) begin
                    md <= M_RX; bidx <= '0; bitn <= '0; ph <= '0; armed <= term;
                  end
                end else if (txv) begin
                  if (!req_hold) begin
                    md <= M_TX; sw <= txh; txv <= 1'b0;
                    bidx <= '0; bitn <= '0; ph <= '0; armed <= term;
                  end
                end else if (term) begin
                  st <= S_STOP; ph <= '0;
                end
              end
            endcase
          end
          default: ;
        endcase
      end

      if (tx_wr) begin
        if (st == S_IDLE) begin
          st <= S_START; md <= M_ADDR; ph <= '0; bitn <= '0; bidx <= '0;
          sw <= {tx_data[23:16], 16'h0000}; rw <= tx_data[16];
          bus_err <= 1'b0; term <= 1'b0; armed <= 1'b0; div_cnt <= '0;
        end else begin
          txh <= tx_data; txv <= 1'b1;
        end
      end
      if (idle_req && st != S_IDLE) term <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= rx_word;
        wp <= (wp == PW'(FIFO_DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(FIFO_DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/i2c_word_master_chk.sv
module i2c_word_master_chk #(
  parameter int FIFO_DEPTH = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [1:0]                      st,
  input logic [1:0]                      md,
  input logic [1:0]                      ph,
  input logic [3:0]                      bitn,
  input logic                            tick,
  input logic                            ackin,
  input logic                            scl_low,
  input logic                            sda_low,
  input logic                            bus_err,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] cnt,
  input logic                            full,
  input logic                            last_b,
  input logic                            push,
  input logic                            rx_ne
);
  localparam logic [1:0] XFER = 2'd2, STOP = 2'd3, RX = 2'd2;

  assert_sda_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XFER && $past(st) == XFER && !scl_low && !$past(scl_low)) |-> $stable(sda_low));

  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

  assert_full_holds_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XFER && md == RX && bitn == 4'd8 && ph == 2'd0 && last_b && full) |=> scl_low);

  // covers the address NACK of R3 as well
  assert_nack_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == XFER && md != RX && bitn == 4'd8 && ph == 2'd3 && tick && ackin) |=> (st == STOP && bus_err));

  assert_err_in_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> st == STOP);

  assert_ne_by_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ne) |-> $past(push));
endmodule

bind i2c_word_master i2c_word_master_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .st(st), .md(md), .ph(ph), .bitn(bitn), .tick(tick),
  .ackin(ackin), .scl_low(scl_low), .sda_low(sda_low), .bus_err(bus_err),
  .cnt(cnt), .full(full), .last_b(last_b), .push(push), .rx_ne(rx_ne)
);

// File: tb/i2c_word_master_tb.sv
`timescale 1ns/1ps
module i2c_word_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  clk_div = 8'd1;
  logic [1:0]  word_len = 2'd0;
  logic        req_en = 1'b0, irq_en = 1'b0, tx_wr = 1'b0, idle_req = 1'b0, rx_rd = 1'b0, req_in = 1'b0;
  logic [23:0] tx_data = '0;
  logic [23:0] rx_data;
  logic        rx_ne, tx_empty, bus_err, irq, idle, scl_low, sda_low, sda_in;

  i2c_word_master dut_i (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .word_len(word_len), .req_en(req_en),
    .irq_en(irq_en), .tx_wr(tx_wr), .tx_data(tx_data), .idle_req(idle_req), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_ne(rx_ne), .tx_empty(tx_empty), .bus_err(bus_err), .irq(irq),
    .idle(idle), .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_in), .req_in(req_in)
  );

  // ---------------- target model ----------------
  logic       s_drive = 1'b0;
  wire        scl_line = !scl_low;
  wire        sda_line = !(sda_low || s_drive);
  assign sda_in = sda_line;

  logic       addr_nack = 1'b0;
  int         nack_idx = -1;
  logic [7:0] src [8];
  logic [7:0] rec [8];
  logic       mack [8];
  logic [7:0] abyte = '0;
  int         rn = 0, mn = 0, stops = 0, period = 0;
  longint     cyc = 0, last_rise = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic p_scl = 1'b1, p_sda = 1'b1, active = 1'b0, s_addr = 1'b0, s_read = 1'b0, ackd = 1'b0, last_mack = 1'b1;
  int   sb = 0, si = 0;
  logic [7:0] sh = '0;

  always @(negedge clk) begin
    if (p_scl && scl_line && p_sda && !sda_line) begin
      active = 1; sb = 0; s_addr = 1; s_read = 0; ackd = 0; s_drive = 0; rn = 0; mn = 0; si = 0;
    end else if (p_scl && scl_line && !p_sda && sda_line) begin
      active = 0; s_drive = 0; stops++;
    end else if (active && scl_line && !p_scl) begin
      if (sb < 8) begin
        if (sb >= 1) period = int'(cyc - last_rise);
        if (!s_read || s_addr) sh = {sh[6:0], sda_line};
        sb++;
      end else begin
        if (s_read && !s_addr) begin mack[mn % 8] = sda_line; mn++; last_mack = sda_line; end
        ackd = 1;
      end
      last_rise = cyc;
    end else if (active && !scl_line && p_scl) begin
      if (sb == 8 && !ackd) begin
        if (s_addr) begin abyte = sh; s_read = sh[0]; s_drive = !addr_nack; end
        else if (!s_read) begin rec[rn % 8] = sh; s_drive = (rn != nack_idx); rn++; end
        else s_drive = 0;
      end else if (sb == 8 && ackd) begin
        sb = 0; ackd = 0;
        if (s_read && ((s_addr && !addr_nack) || (!s_addr && !last_mack))) begin
          sh = src[si % 8]; si++; s_drive = !sh[7];
        end else s_drive = 0;
        s_addr = 0;
      end else if (active && s_read && !s_addr && sb > 0 && sb < 8) begin
        s_drive = !sh[7 - sb];
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic term();
    @(negedge clk); idle_req = 1'b1;
    @(negedge clk); idle_req = 1'b0;
  endtask

  task automatic pop(output logic [23:0] v);
    @(negedge clk); v = rx_data; rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int g = 0;
    while (!idle && g < 20000) begin @(negedge clk); g++; end
    chk(idle, req, idle, 1);
  endtask

  function automatic int nbytes(input logic [1:0] wl);
    return (wl == 2'd1) ? 2 : (wl == 2'd2) ? 3 : 1;
  endfunction

  function automatic logic [23:0] wmask(input int n);
    return (n == 1) ? 24'hFF0000 : (n == 2) ? 24'hFFFF00 : 24'hFFFFFF;
  endfunction

  // {rw, word_len, word}
  localparam logic [26:0] VEC [7] = '{
    {1'b0, 2'd0, 24'hA53C0F},
    {1'b0, 2'd1, 24'h81C3E7},
    {1'b0, 2'd2, 24'h5A6B7C},
    {1'b0, 2'd3, 24'h3EFFFF},
    {1'b1, 2'd0, 24'hC60000},
    {1'b1, 2'd1, 24'h1BE400},
    {1'b1, 2'd2, 24'h9D2A71}
  };

  task automatic run_vec(input logic [26:0] v);
    logic        rw = v[26];
    logic [1:0]  wl = v[25:24];
    logic [23:0] w = v[23:0];
    int          n = nbytes(wl);
    int          st0 = stops;
    logic [7:0]  ab = {7'h2B, rw};
    logic [23:0] got;
    word_len = wl;
    for (int k = 0; k < 8; k++) src[k] = 8'(w >> (16 - 8 * (k % n)));
    wr({ab, 16'hFFFF});
    if (!rw) wr(w);
    term();
    wait_idle(rw ? "R8" : "R6");
    chk(abyte == ab, "R2", abyte, ab);
    chk(stops == st0 + 1, rw ? "R8" : "R5", stops, st0 + 1);
    if (!rw) begin
      got = {rec[0], rec[1], rec[2]} & wmask(n);
      chk(rn == n, "R4", rn, n);
      chk(got == (w & wmask(n)), "R5", got, w & wmask(n));
    end else begin
      pop(got);
      chk(got == (w & wmask(n)), "R7", got, w & wmask(n));
      chk(mn == n && mack[(n - 1) % 8] == 1'b1, "R8", mn, n);
      chk(!rx_ne, "R7", rx_ne, 0);
    end
  endtask

  initial begin
    logic [23:0] got [8];
    int nw, g, st0;
    for (int k = 0; k < 8; k++) begin src[k] = '0; rec[k] = '0; mack[k] = 1'b1; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(idle == 1'b1, "R1", idle, 1);
    chk(scl_low == 1'b0 && sda_low == 1'b0, "R1", {scl_low, sda_low}, 0);
    chk(rx_ne == 1'b0 && tx_empty == 1'b1, "R1", {rx_ne, tx_empty}, 1);
    chk(bus_err == 1'b0 && irq == 1'b0, "R1", {bus_err, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[i]) run_vec(VEC[i]);
    chk(period == 4 * (clk_div + 1), "R11", period, 4 * (clk_div + 1));

    // R3 address NACK with interrupt
    irq_en = 1'b1; addr_nack = 1'b1; word_len = 2'd0; st0 = stops;
    wr({7'h11, 1'b0, 16'h0});
    wait_idle("R3");
    chk(bus_err == 1'b1 && irq == 1'b1, "R3", {bus_err, irq}, 3);
    chk(stops == st0 + 1 && rn == 0, "R3", rn, 0);
    addr_nack = 1'b0;

    // R2 terminate while idle is ignored
    term();
    repeat (20) @(negedge clk);
    chk(idle == 1'b1 && scl_low == 1'b0, "R2", idle, 1);

    // R3 clear on new session, R5 NACK on first data byte
    word_len = 2'd1; nack_idx = 0;
    wr({7'h22, 1'b0, 16'h0});
    chk(bus_err == 1'b0, "R3", bus_err, 0);
    wr(24'h1234AA);
    wait_idle("R5");
    chk(bus_err == 1'b1, "R5", bus_err, 1);
    chk(rn == 1 && rec[0] == 8'h12, "R5", rn, 1);
    nack_idx = -1; irq_en = 1'b0;

    // R6 stall with no data, then resume
    word_len = 2'd0;
    wr({7'h33, 1'b0, 16'h0});
    repeat (300) @(negedge clk);
    chk(idle == 1'b0 && scl_low == 1'b1, "R6", {idle, scl_low}, 1);
    chk(rn == 0, "R6", rn, 0);
    wr(24'h5A0000);
    repeat (10) @(negedge clk);
    chk(tx_empty == 1'b1, "R5", tx_empty, 1);
    term();
    wait_idle("R6");
    chk(rn == 1 && rec[0] == 8'h5A, "R6", rec[0], 8'h5A);

    // R6 terminate while stalled without data
    st0 = stops;
    wr({7'h34, 1'b0, 16'h0});
    repeat (150) @(negedge clk);
    term();
    wait_idle("R6");
    chk(rn == 0 && stops == st0 + 1 && bus_err == 1'b0, "R6", rn, 0);

    // R9 FIFO full stall, then R8 terminate and drain
    word_len = 2'd0;
    for (int k = 0; k < 8; k++) src[k] = 8'h40 + 8'(k);
    wr({7'h35, 1'b1, 16'h0});
    repeat (800) @(negedge clk);
    chk(rx_ne == 1'b1 && scl_low == 1'b1 && idle == 1'b0, "R9", {rx_ne, scl_low, idle}, 3);
    chk(mn == 4, "R9", mn, 4);
    term();
    nw = 0; g = 0;
    do begin
      @(negedge clk); rx_rd = 1'b0;
      if (rx_ne) begin got[nw % 8] = rx_data; nw++; rx_rd = 1'b1; end
      g++;
    end while (!(idle && !rx_ne && !rx_rd) && g < 20000);
    rx_rd = 1'b0;
    chk(nw == 6, "R8", nw, 6);
    begin
      logic ok = 1'b1;
      for (int k = 0; k < 6; k++) if (got[k] != {8'h40 + 8'(k), 16'h0}) ok = 1'b0;
      chk(ok, "R9", got[4], 24'h440000);
    end
    chk(mn == 6 && mack[5] == 1'b1 && mack[4] == 1'b0, "R8", mn, 6);

    // R10 ready handshake
    req_en = 1'b1; req_in = 1'b0;
    wr({7'h36, 1'b0, 16'h0});
    wr(24'h990000);
    repeat (300) @(negedge clk);
    chk(abyte == {7'h36, 1'b0} && rn == 0 && scl_low == 1'b1, "R10", rn, 0);
    req_in = 1'b1;
    term();
    wait_idle("R10");
    chk(rn == 1 && rec[0] == 8'h99, "R10", rec[0], 8'h99);
    req_en = 1'b0; req_in = 1'b0;

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule